// File: doc/BRIEF.md
# Bump-Switch Obstacle Avoidance Controller

This block steers a two-wheeled robot from two contact switches, one mounted on the left and one on the right. While neither switch is touched the robot drives straight ahead. When one switch makes contact, the robot reverses for a fixed number of clock cycles. It then pivots away from the side that was struck for another fixed number of cycles, and after that it resumes driving ahead.

Each raw switch line first passes through a two-flop synchronizer. A debounce filter then accepts a new level only after that level has held steady for a set number of cycles. A small state machine reads the filtered levels. The state machine has two reversing states, one per pivot direction, so the turn direction is held in the state itself and does not depend on the switch, which has usually been released by the time the reversing ends. A separate timer datapath measures how long each timed state lasts. The state machine clears the timer when it enters a timed state, and the timer reports when the final count is reached.

The wheel outputs are per-wheel motion codes meant for a downstream servo or motor pulse stage.

Top module: `bump_avoid_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to the drive-ahead state with its timer cleared. From the next cycle both wheel outputs read 01 (forward).
- R2: While no switch press has been accepted, both wheels stay at 01 and the controller does not leave the drive-ahead state.
- R3: An accepted press of the left switch (line high = pressed) makes both wheels 10 (reverse). The robot then turns right, with the left wheel at 01 and the right wheel at 10.
- R4: An accepted press of the right switch makes both wheels 10. The robot then turns left, with the left wheel at 10 and the right wheel at 01.
- R5: If both switches are accepted as pressed in the same cycle while driving ahead, the left switch wins and the robot turns right.
- R6: The reverse phase lasts exactly BACK_CYCLES cycles and the turn phase lasts exactly TURN_CYCLES cycles. Each phase ends by itself, with no switch activity. The timer's terminal flag is high only in the last cycle of each phase.
- R7: A switch level is accepted only after the synchronized line has differed from the accepted level for STABLE_CYCLES consecutive cycles. For a press that starts before clock edge 1, the wheel outputs change after edge 3+STABLE_CYCLES. A press shorter than STABLE_CYCLES cycles has no effect.
- R8: Switch activity during the reverse or turn phases is ignored. It changes neither the wheel outputs nor the phase timing.
- R9: The turn direction is set by the reverse state that was taken, and it holds even though the switch was released during the reverse phase.
- R10: The wheel code 11 never appears on either wheel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_left | input | 1 | Left contact switch, high while pressed |
| sw_right | input | 1 | Right contact switch, high while pressed |
| wheel_left | output | 2 | Left wheel command: 00 stop, 01 forward, 10 reverse |
| wheel_right | output | 2 | Right wheel command: 00 stop, 01 forward, 10 reverse |

## Verification
The hardest case to reach from the ports is a switch event on the opposite side that the filter accepts while the robot is reversing or turning. The stimulus has to time a second press so that it clears the debounce filter inside the timed phases and is released again before the drive-ahead state returns. The bench computes the edge numbers from the filter length and the two phase lengths. It then shows that the turn direction and the phase boundaries do not move. Press lengths on each side, and on both sides together, are swept across the debounce threshold, and each resulting wheel trace is compared cycle by cycle against the expected trace.

// File: rtl/bump_avoid_ctrl.sv
`timescale 1ns/1ps
module bump_avoid_ctrl #(
  parameter int unsigned STABLE_CYCLES = 4,
  parameter int unsigned BACK_CYCLES   = 50,
  parameter int unsigned TURN_CYCLES   = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_left,
  input  logic       sw_right,
  output logic [1:0] wheel_left,
  output logic [1:0] wheel_right
);
  localparam int unsigned DW   = $clog2(STABLE_CYCLES + 1);
  localparam int unsigned TMAX = (BACK_CYCLES > TURN_CYCLES) ? BACK_CYCLES : TURN_CYCLES;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  localparam logic [2:0] ST_FWD  = 3'd0;
  localparam logic [2:0] ST_BK_R = 3'd1;
  localparam logic [2:0] ST_BK_L = 3'd2;
  localparam logic [2:0] ST_TN_R = 3'd3;
  localparam logic [2:0] ST_TN_L = 3'd4;

  localparam logic [1:0] W_STOP = 2'b00;
  localparam logic [1:0] W_FWD  = 2'b01;
  localparam logic [1:0] W_REV  = 2'b10;

  logic [1:0] raw, deb;
  assign raw = {sw_right, sw_left};

  for (genvar i = 0; i < 2; i++) begin : g_db
    logic m, s, d;
    logic [DW-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) begin
        m <= 1'b0;
        s <= 1'b0;
        d <= 1'b0;
        c <= '0;
      end else begin
        m <= raw[i];
        s <= m;
        if (s == d) begin
          c <= '0;
        end else if (c == DW'(STABLE_CYCLES - 1)) begin
          d <= s;
          c <= '0;
        end else begin
          c <= c + 1'b1;
        end
      end
    end
    assign deb[i] = d;
  end

  logic [2:0] state, next;
  logic [TW-1:0] tmr;
  logic done, in_back, in_turn;

  assign in_back = (state == ST_BK_R) || (state == ST_BK_L);
  assign in_turn = (state == ST_TN_R) || (state == ST_TN_L);
  assign done = (in_back && tmr == TW'(BACK_CYCLES - 1)) ||
                (in_turn && tmr == TW'(TURN_CYCLES - 1));

  always_comb begin
    next = state;
    case (state)
      ST_FWD:  if (deb[0]) next = ST_BK_R;
               else if (deb[1]) next = ST_BK_L;
      ST_BK_R: if (done) next = ST_TN_R;
      ST_BK_L: if (done) next = ST_TN_L;
      ST_TN_R, ST_TN_L: if (done) next = ST_FWD;
      default: next = ST_FWD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FWD;
      tmr   <= '0;
    end else begin
      state <= next;
      tmr   <= (next != state || state == ST_FWD) ? '0 : tmr + 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_FWD:           begin wheel_left = W_FWD; wheel_right = W_FWD; end
      ST_BK_R, ST_BK_L: begin wheel_left = W_REV; wheel_right = W_REV; end
      ST_TN_R:          begin wheel_left = W_FWD; wheel_right = W_REV; end
      ST_TN_L:          begin wheel_left = W_REV; wheel_right = W_FWD; end
      default:          begin wheel_left = W_STOP; wheel_right = W_STOP; end
    endcase
  end
endmodule

module bump_avoid_ctrl_chk #(
  parameter int unsigned TW = 6,
  parameter int unsigned BACK_CYCLES = 50,
  parameter int unsigned TURN_CYCLES = 40
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    state,
  input logic [TW-1:0] tmr,
  input logic [1:0]    deb,
  input logic          done,
  input logic [1:0]    wheel_left,
  input logic [1:0]    wheel_right
);
  a_r1_reset_forward: assert property (@(posedge clk) rst |=> (state == 3'd0 && tmr == '0));
  a_r2_hold_forward: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && deb == 2'b00) |=> state == 3'd0);
  a_r3_left_backup: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && deb[0]) |=> state == 3'd1);
  a_r4_right_backup: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && deb == 2'b10) |=> state == 3'd2);
  a_r6_back_bound: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 || state == 3'd2) |-> tmr <= TW'(BACK_CYCLES - 1));
  a_r6_turn_bound: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd3 || state == 3'd4) |-> tmr <= TW'(TURN_CYCLES - 1));
  a_r8_timed_hold: assert property (@(posedge clk) disable iff (rst)
    (state != 3'd0 && !done) |=> $stable(state));
  a_r9_turn_right: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && done) |=> state == 3'd3);
  a_r9_turn_left: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && done) |=> state == 3'd4);
  a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
    wheel_left != 2'b11 && wheel_right != 2'b11);
endmodule

bind bump_avoid_ctrl bump_avoid_ctrl_chk #(
  .TW(TW), .BACK_CYCLES(BACK_CYCLES), .TURN_CYCLES(TURN_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .state(state), .tmr(tmr), .deb(deb), .done(done),
  .wheel_left(wheel_left), .wheel_right(wheel_right)
);

// File: tb/bump_avoid_ctrl_test.sv
`timescale 1ns/1ps
module bump_avoid_ctrl_test;
  localparam int S = 3;
  localparam int B = 5;
  localparam int T = 4;
  localparam int N = 3 + S + B + T + 3;

  logic clk = 1'b0, rst = 1'b1, sw_left = 1'b0, sw_right = 1'b0;
  logic [1:0] wheel_left, wheel_right;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bump_avoid_ctrl #(.STABLE_CYCLES(S), .BACK_CYCLES(B), .TURN_CYCLES(T)) uut (
    .clk(clk), .rst(rst), .sw_left(sw_left), .sw_right(sw_right),
    .wheel_left(wheel_left), .wheel_right(wheel_right));

  task automatic check(input string req, input logic [1:0] el, input logic [1:0] er);
    checks++;
    if (wheel_left !== el || wheel_right !== er) begin
      fails++;
      $display("FAIL %s: wheels %b/%b expected %b/%b at %0t", req, wheel_left, wheel_right, el, er, $time);
    end
  endtask

  task automatic idle(input int n);
    sw_left = 0; sw_right = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      check("R2 idle forward", 2'b01, 2'b01);
    end
  endtask

  // l/r: which side is pressed for h cycles; opp: opposite-side pulse of 3 cycles
  // starting at edge 3+S+1, which lands inside the reverse phase (R8).
  task automatic episode(input bit l, input bit r, input int h, input bit opp);
    bit go_right;
    string req;
    go_right = l;
    req = (l && r) ? "R5 both" : (l ? "R3 left" : "R4 right");
    for (int n = 1; n <= N; n++) begin
      logic [1:0] el, er;
      bit pulse;
      pulse = opp && n >= 3 + S + 1 && n < 3 + S + 4;
      sw_left  = (l && n <= h) || (pulse && !l);
      sw_right = (r && n <= h) || (pulse && l);
      @(posedge clk); @(negedge clk);
      if (h < S || n < 3 + S) begin el = 2'b01; er = 2'b01; end
      else if (n < 3 + S + B) begin el = 2'b10; er = 2'b10; end
      else if (n < 3 + S + B + T) begin
        el = go_right ? 2'b01 : 2'b10;
        er = go_right ? 2'b10 : 2'b01;
      end else begin el = 2'b01; er = 2'b01; end
      if (opp) check({"R8 ", req}, el, er);
      else if (h < S) check("R7 short press ignored", el, er);
      else if (n == 3 + S) check({"R7 latency ", req}, el, er);
      else if (n >= 3 + S + B) check({"R6 R9 phase ", req}, el, er);
      else check(req, el, er);
    end
    idle(4);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    sw_left = 1; sw_right = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset forward", 2'b01, 2'b01);
    sw_left = 0; sw_right = 0;
    rst = 0;
    idle(6);
    for (int h = 1; h <= 6; h++) begin
      episode(1, 0, h, 0);
      episode(0, 1, h, 0);
      episode(1, 1, h, 0);
    end
    episode(1, 0, 3, 1);
    episode(0, 1, 4, 1);
    sw_left = 1;
    for (int n = 1; n <= 3 + S + 1; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 3 + S + 1) check("R3 reverse before reset", 2'b10, 2'b10);
    end
    sw_left = 0;
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid phase", 2'b01, 2'b01);
    rst = 0;
    idle(B + T + 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule